// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 24 maskable interrupt requests, latches each rising edge of a request line into a pending flag and chooses among the pending sources whose enables are on. When the processor signals that the current instruction is in its final cycle, the controller hands over the call target of the winning source together with its index and a one-cycle accept pulse. The processor's stack push and the call itself lie outside this block. Programmable priority levels are also outside it: only the fixed order is built.

Software reaches the controller through a small register port. Four enable registers hold six source enables each, and the first of them also holds the master enable. Four flag registers expose the pending state. A parameter mask decides which sources lose their flag when serviced, and a second mask marks the sources whose flag cannot be read. The reset entry point at 0000h is presented on the vector output after reset and cannot be masked.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Synchronous reset clears all pending flags, all source enables and the master enable, drops `irq_accept`, sets `irq_id` to 0 and sets `irq_vector` to 0000h.
- R2: A rising edge on `irq_req[n]` sets flag n at the clock edge where it is sampled. A request held high does not set the flag again once cleared. A new edge arriving in the same cycle as a software clear of that flag leaves the flag set.
- R3: Addresses 0 to 3 are enable registers: register k, bit b enables source 6k+b (b = 0..5), and bit 6 of register 0 is the master enable. Reads return the register one clock after the address is presented.
- R4: Addresses 4 to 7 are flag registers with the same bit layout (address 4+k, bit b = source 6k+b). Writing 0 to a bit clears that flag, writing 1 has no effect. Sources 4, 17 and 22 have no readable flag: their bits read 0 and software writes do not clear them.
- R5: A source is accepted only when its flag is set, its own enable is set and the master enable is set, at a clock edge where `insn_end` is high.
- R6: When several sources qualify, the lowest-numbered one is accepted.
- R7: On acceptance `irq_id` equals the source number n and `irq_vector` equals 0003h + 8·n (0003h for source 0, 00BBh for source 23).
- R8: `irq_accept` rises for exactly one cycle after the accepting edge. At that same edge the flag of the accepted source is cleared, except for sources 6, 9 and 11, whose flags stay set until software clears them.
- R9: An `insn_end` sampled while `irq_accept` is high is ignored; the next acceptance needs a later boundary strobe.
- R10: A flag whose enable is off stays pending and is accepted at a boundary after the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 24 | Request lines, rising-edge sensitive |
| insn_end | input | 1 | High in the final cycle of an instruction |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: bit 2 selects flags, bits 1:0 the register |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Registered read data for the addressed register |
| irq_accept | output | 1 | One-cycle pulse when a source is accepted |
| irq_id | output | 5 | Index of the accepted source |
| irq_vector | output | 16 | Call target of the accepted source; 0000h after reset |

## Verification
The assertions take for granted that the request lines and the boundary strobe are driven with defined levels from the first clock edge of reset onward, since edge detection compares each line with its value one cycle earlier; the bench holds all requests low and the strobe low throughout reset. They also assume the vector and index are only meaningful while the accept pulse is high, and they check them only there. The stimulus changes inputs only on the falling clock edge, so every request edge, register write and boundary strobe is seen at a single rising edge, and it sweeps every source alone and every ordered pair of sources against the computed vector and priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Half of the register space selected by the top address bit.
  typedef enum logic {
    BANK_ENABLE = 1'b0,
    BANK_FLAG   = 1'b1
  } reg_bank_e;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned NSRC = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] svc_clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;

  // Tracks the line even in reset, so no spurious edge appears afterwards.
  always_ff @(posedge clk) req_q <= req;

  assign rise = req & ~req_q;

  // A fresh edge takes precedence over either kind of clear.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~sw_clr & ~svc_clr) | rise;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned NSRC = 24,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic            valid,
  output logic [IDW-1:0]  idx
);
  always_comb begin
    valid = |cand;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDW'(i);
    end
  end
endmodule

// File: rtl/irqc_csr.sv
module irqc_csr
  import irqc_pkg::*;
#(
  parameter int unsigned     NSRC    = 24,
  parameter int unsigned     PER_REG = 6,
  parameter logic [NSRC-1:0] NOREAD  = '0,
  localparam int unsigned NREG  = (NSRC + PER_REG - 1) / PER_REG,
  localparam int unsigned IW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned AW    = IW + 1,
  localparam int unsigned REG_W = PER_REG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  pend,
  output logic [REG_W-1:0] rdata,
  output logic [NSRC-1:0]  en,
  output logic             gie,
  output logic [NSRC-1:0]  flag_clr
);
  reg_bank_e         bank;
  logic [IW-1:0]     sel;
  logic [REG_W-1:0]  rd_next;

  assign bank = reg_bank_e'(addr[AW-1]);
  assign sel  = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      gie <= 1'b0;
    end else if (we && bank == BANK_ENABLE) begin
      for (int k = 0; k < NREG; k++) begin
        for (int b = 0; b < PER_REG; b++) begin
          if (k * PER_REG + b < NSRC && sel == IW'(k)) en[k * PER_REG + b] <= wdata[b];
        end
      end
      if (sel == '0) gie <= wdata[REG_W-1];
    end
  end

  // Software clears only reach flags that software can see.
  always_comb begin
    flag_clr = '0;
    for (int k = 0; k < NREG; k++) begin
      for (int b = 0; b < PER_REG; b++) begin
        if (k * PER_REG + b < NSRC) begin
          if (we && bank == BANK_FLAG && sel == IW'(k) && !wdata[b] && !NOREAD[k * PER_REG + b])
            flag_clr[k * PER_REG + b] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NREG; k++) begin
      for (int b = 0; b < PER_REG; b++) begin
        if (k * PER_REG + b < NSRC && sel == IW'(k)) begin
          if (bank == BANK_FLAG) rd_next[b] = pend[k * PER_REG + b] & ~NOREAD[k * PER_REG + b];
          else                   rd_next[b] = en[k * PER_REG + b];
        end
      end
    end
    if (bank == BANK_ENABLE && sel == '0) rd_next[REG_W-1] = gie;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned     NSRC      = 24,
  parameter int unsigned     PER_REG   = 6,
  parameter int unsigned     VEC_W     = 16,
  parameter int unsigned     VEC_BASE  = 3,
  parameter int unsigned     VEC_STEP  = 8,
  parameter int unsigned     RESET_VEC = 0,
  parameter logic [NSRC-1:0] AUTOCLR   = 24'hFFF5BF,
  parameter logic [NSRC-1:0] NOREAD    = 24'h420010,
  localparam int unsigned NREG  = (NSRC + PER_REG - 1) / PER_REG,
  localparam int unsigned AW    = ((NREG > 1) ? $clog2(NREG) : 1) + 1,
  localparam int unsigned REG_W = PER_REG + 1,
  localparam int unsigned IDW   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             insn_end,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_accept,
  output logic [IDW-1:0]   irq_id,
  output logic [VEC_W-1:0] irq_vector
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag_clr;
  logic [NSRC-1:0] svc_clr;
  logic [NSRC-1:0] cand;
  logic            gie;
  logic            win_v;
  logic [IDW-1:0]  win_id;
  logic            grant;

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req(irq_req), .sw_clr(flag_clr), .svc_clr(svc_clr), .pend(pend)
  );

  irqc_csr #(.NSRC(NSRC), .PER_REG(PER_REG), .NOREAD(NOREAD)) u_csr (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .pend(pend),
    .rdata(reg_rdata), .en(en), .gie(gie), .flag_clr(flag_clr)
  );

  assign cand = pend & en & {NSRC{gie}};

  irqc_prio #(.NSRC(NSRC)) u_prio (.cand(cand), .valid(win_v), .idx(win_id));

  // The cycle showing an accept swallows any boundary strobe.
  assign grant   = insn_end & win_v & ~irq_accept;
  assign svc_clr = grant ? (AUTOCLR & (NSRC'(1) << win_id)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_accept <= 1'b0;
      irq_id     <= '0;
      irq_vector <= VEC_W'(RESET_VEC);
    end else begin
      irq_accept <= grant;
      if (grant) begin
        irq_id     <= win_id;
        irq_vector <= VEC_W'(VEC_BASE + VEC_STEP * win_id);
      end
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned     NSRC     = 24,
  parameter int unsigned     VEC_W    = 16,
  parameter int unsigned     VEC_BASE = 3,
  parameter int unsigned     VEC_STEP = 8,
  parameter logic [NSRC-1:0] AUTOCLR  = '1,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  req,
  input logic             insn_end,
  input logic             accept,
  input logic [IDW-1:0]   id,
  input logic [VEC_W-1:0] vector,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  cand
);
  logic [NSRC-1:0] req_p, rise, rise_p, cand_p, low_mask;
  logic            ins_p;

  always_ff @(posedge clk) begin
    req_p  <= req;
    rise_p <= rise;
    cand_p <= cand;
    ins_p  <= insn_end;
  end

  assign rise     = req & ~req_p;
  assign low_mask = (NSRC'(1) << id) - NSRC'(1);

  a_r2_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  a_r5_gated_accept: assert property (@(posedge clk) disable iff (rst)
    accept |-> (ins_p && cand_p[id]));

  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((cand_p & low_mask) == '0));

  a_r7_vector_match: assert property (@(posedge clk) disable iff (rst)
    accept |-> (vector == VEC_W'(VEC_BASE + VEC_STEP * id)));

  a_r8_autoclear: assert property (@(posedge clk) disable iff (rst)
    (accept && AUTOCLR[id] && !rise_p[id]) |-> !pend[id]);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
endmodule

bind irq_vector_ctrl irqc_chk #(
  .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .AUTOCLR(AUTOCLR)
) u_chk (
  .clk(clk), .rst(rst), .req(irq_req), .insn_end(insn_end), .accept(irq_accept),
  .id(irq_id), .vector(irq_vector), .pend(pend), .cand(cand)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] irq_req = '0;
  logic        insn_end = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [6:0]  reg_wdata = '0;
  logic [6:0]  reg_rdata;
  logic        irq_accept;
  logic [4:0]  irq_id;
  logic [15:0] irq_vector;

  int n_checks = 0;
  int n_fail   = 0;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .insn_end(insn_end), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_accept(irq_accept), .irq_id(irq_id), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit readable(int n);
    return !(n == 4 || n == 17 || n == 22);
  endfunction

  function automatic bit autoclr(int n);
    return !(n == 6 || n == 9 || n == 11);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 7'(d);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 3'(a);
    tick();
    d = int'(reg_rdata);
  endtask

  task automatic pulse(int n);
    irq_req[n] = 1'b1;
    tick();
    irq_req[n] = 1'b0;
  endtask

  // One idle cycle lets any earlier accept drop before the strobe.
  task automatic boundary(output int acc, output int id, output int vec);
    tick();
    insn_end = 1'b1;
    tick();
    acc = int'(irq_accept); id = int'(irq_id); vec = int'(irq_vector);
    insn_end = 1'b0;
  endtask

  task automatic enable_all();
    wr(0, 7'h7F); wr(1, 7'h3F); wr(2, 7'h3F); wr(3, 7'h3F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int d, acc, id, vec;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 accept", int'(irq_accept), 0);
    check("R1 vector", int'(irq_vector), 0);
    check("R1 id", int'(irq_id), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check("R1 register", d, 0);
    end

    // Single-source sweep: R3 R4 R5 R7 R8
    for (int n = 0; n < 24; n++) begin
      int k, b;
      k = n / 6; b = n % 6;
      for (int r = 0; r < 4; r++) wr(r, (r == k) ? (1 << b) : 0);
      rd(k, d);
      check("R3 enable readback", d, 1 << b);
      pulse(n);
      rd(4 + k, d);
      check("R4 flag read", d, readable(n) ? (1 << b) : 0);
      boundary(acc, id, vec);
      check("R5 master off blocks", acc, 0);
      wr(0, ((k == 0) ? (1 << b) : 0) | 7'h40);
      boundary(acc, id, vec);
      check("R8 accept", acc, 1);
      check("R7 id", id, n);
      check("R7 vector", vec, 3 + 8 * n);
      rd(4 + k, d);
      check("R8 flag after service", d, autoclr(n) ? 0 : (1 << b));
      if (!autoclr(n)) begin
        wr(4 + k, 7'h3F & ~(1 << b));
        rd(4 + k, d);
        check("R4 software clear", d, 0);
      end
      boundary(acc, id, vec);
      check("R8 nothing left", acc, 0);
    end

    // R4: a source without readable flag ignores software clear
    for (int r = 0; r < 4; r++) wr(r, 0);
    pulse(17);
    wr(6, 0);
    wr(0, 7'h40); wr(2, 7'h20);
    boundary(acc, id, vec);
    check("R4 hidden flag survives clear", acc, 1);
    check("R4 hidden flag id", id, 17);

    // R6: every ordered pair
    enable_all();
    for (int n = 0; n < 23; n++) begin
      for (int m = n + 1; m < 24; m++) begin
        pulse(m);
        pulse(n);
        boundary(acc, id, vec);
        check("R6 lowest index", id, n);
        for (int r = 4; r < 8; r++) wr(r, 0);
        boundary(acc, id, vec);
      end
    end

    // R9: strobe held across the accept cycle
    pulse(1);
    pulse(2);
    insn_end = 1'b1;
    tick();
    check("R9 first accept", int'(irq_accept), 1);
    check("R9 first id", int'(irq_id), 1);
    tick();
    check("R9 strobe ignored", int'(irq_accept), 0);
    tick();
    check("R9 next accept", int'(irq_accept), 1);
    check("R9 next id", int'(irq_id), 2);
    insn_end = 1'b0;
    tick();

    // R10: pending held while disabled
    for (int r = 0; r < 4; r++) wr(r, 0);
    wr(0, 7'h40);
    pulse(5);
    boundary(acc, id, vec);
    check("R10 disabled holds", acc, 0);
    wr(0, 7'h60);
    boundary(acc, id, vec);
    check("R10 taken later", acc, 1);
    check("R10 id", id, 5);

    // R2: edge against same-cycle clear, then level held
    for (int r = 0; r < 4; r++) wr(r, 0);
    pulse(0);
    irq_req[3] = 1'b1;
    wr(4, 0);
    rd(4, d);
    check("R2 edge wins over clear", d, 8);
    wr(4, 0);
    rd(4, d);
    check("R2 level does not retrigger", d, 0);
    irq_req[3] = 1'b0;
    tick();

    // R1: reset in the middle of activity
    enable_all();
    pulse(8);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    rd(0, d);
    check("R1 enables cleared", d, 0);
    rd(5, d);
    check("R1 flags cleared", d, 0);
    check("R1 vector back to reset entry", int'(irq_vector), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule